// File: doc/BRIEF.md
# PHY Control Register Bank with Masked Writes

This block holds the static control settings of a storage-interface PHY and presents each setting as a dedicated output wire. Software reaches the bank over a simple 32-bit register bus. Every write carries its own per-bit enable in the upper half of the data word, so the low half changes only where the upper half says so. A driver can therefore flip the power-up bit or retune the DLL frequency without first reading the word back.

Six control words drive the PHY pins. The first sets the DLL frequency band and the transmit and receive tap delays. Four lane words each give an 8-bit data-lane field plus command and strobe bits, used for receiver enable, pull-up, open-drain release and open-drain enable. The last word sets DLL trim, retrim, drive type, retention, DLL enable and power-up. A seventh, read-only word returns the calibration and DLL status that the PHY reports. Those inputs pass through a two-flop synchronizer before software can read them.

Top module: `phyctl_regbank`

## Requirements
- R1: A write to a control word changes low-half bit n (n < 16) only when data bit n+16 is 1. Every other stored bit keeps its value, and the output ports follow the stored bits on the clock edge that takes the write.
- R2: Word address 0x00 maps bits 13:12 to `freq_sel`, bit 11 to `otap_en`, bits 10:7 to `otap_sel`, bit 6 to `itap_win`, bits 5:1 to `itap_sel` and bit 0 to `itap_en`.
- R3: Word address 0x18 maps bits 12:9 to `dll_trim`, bit 8 to `retrim_en`, bit 7 to `retrim_go`, bits 6:4 to `drv_type`, bits 3:2 to `retain_ctl`, bit 1 to `dll_en` and bit 0 to `pwr_up` (1 = powered).
- R4: Word addresses 0x08, 0x0C, 0x10 and 0x14 drive bits 9:0 onto `pad_rxen`, `pad_pullup`, `pad_odrel` and `pad_oden` respectively, one port bit per register bit.
- R5: A read at 0x20 returns `st_cal_done` in bit 6, `st_dll_rdy` in bit 5, `st_trim` in bits 4:1 and `st_ext_res_absent` in bit 0. Each input is taken through two flops first, so a read issued on the first edge after an input change still returns the old value.
- R6: Writes to 0x20 and to any unmapped word address (0x04, 0x1C, 0x24 to 0x3C) change no stored bit and no output.
- R7: A read with `bus_rd` high presents its result on `bus_rdata` after the next clock edge. The upper 16 bits are always zero, and unmapped addresses read as zero.
- R8: While `rst_n` is low at a clock edge, every control output and `bus_rdata` clear to 0, so the PHY starts powered down with its DLL disabled.
- R9: Bits above a word's defined fields (15:14 at 0x00, 15:10 in lane words, 15:13 at 0x18) cannot be set and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data: 31:16 bit enables, 15:0 values |
| bus_rdata | output | 32 | Registered read data |
| st_cal_done | input | 1 | PHY calibration finished |
| st_dll_rdy | input | 1 | DLL locked |
| st_trim | input | 4 | Calibration trim result |
| st_ext_res_absent | input | 1 | External reference resistor missing |
| freq_sel | output | 2 | DLL frequency band |
| otap_en | output | 1 | Transmit tap delay enable |
| otap_sel | output | 4 | Transmit tap delay select |
| itap_win | output | 1 | Receive tap change window |
| itap_sel | output | 5 | Receive tap delay select |
| itap_en | output | 1 | Receive tap delay enable |
| pad_rxen | output | 10 | Receiver enables (data 7:0, bits 9:8 command/strobe) |
| pad_pullup | output | 10 | Pull-up enables |
| pad_odrel | output | 10 | Open-drain release |
| pad_oden | output | 10 | Open-drain enables |
| dll_trim | output | 4 | DLL charge-pump trim |
| retrim_en | output | 1 | Retrim enable |
| retrim_go | output | 1 | Retrim request |
| drv_type | output | 3 | Output drive type |
| retain_ctl | output | 2 | Retention controls |
| dll_en | output | 1 | DLL enable |
| pwr_up | output | 1 | PHY power-up (0 = powered down) |

## Verification
The bench aims at partial masks: a mask of a single bit, a mask that clears one bit of a word that is already set, and a full value sent under an empty mask. A design that ignored the mask, or took the mask as a write strobe for the whole word, would change neighbouring fields. A design that mixed up value and mask halves would read back the wrong pattern. Writes that carry every enable set go to the status word, to the gap at 0x04 and beyond the last word. A loose decoder would corrupt a control word or let status bits stick. The bench also reads status on the first edge after an input change, where a design with one flop or none would already show the new value. It sets the undefined high bits and expects them to read back as zero. A reset in mid-run must bring the power-up and DLL-enable outputs back to 0.

// File: rtl/phyctl_pkg.sv
// Package: shared sizes and the word map of the PHY control bank.
// Assumes word addressing from byte address bits [ADDR_W-1:2].
package phyctl_pkg;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int ADDR_W   = 6;
    localparam int WIDX_W   = ADDR_W - 2;
    localparam int NUM_CTRL = 6;
    localparam int STAT_W   = 7;
    localparam int LANE_W   = 10;

    localparam logic [WIDX_W-1:0] STAT_WIDX = WIDX_W'(8);

    // Word index of control register i (i = 0 timing, 1..4 lanes, 5 power/DLL).
    function automatic logic [WIDX_W-1:0] ctrl_widx(input int i);
        return (i == 0) ? WIDX_W'(0) : WIDX_W'(i + 1);
    endfunction

    // Implemented (writable) bits of control register i.
    function automatic logic [HALF_W-1:0] ctrl_impl(input int i);
        if (i == 0)
            return HALF_W'(16'h3FFF);
        else if (i == NUM_CTRL - 1)
            return HALF_W'(16'h1FFF);
        else
            return HALF_W'(16'h03FF);
    endfunction
endpackage

// File: rtl/phyctl_masked_reg.sv
// One control word with per-bit write enables carried in the upper data half.
// Assumes the write select is already decoded; bits outside IMPL stay 0.
module phyctl_masked_reg #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    IMPL = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   q
);
    logic [W-1:0] bit_en;

    // Effective enables: requested by the write and present in hardware.
    always_comb bit_en = wdata[2*W-1:W] & IMPL;

    // Update only the enabled bits; keep the rest.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (sel)
            q <= (q & ~bit_en) | (wdata[W-1:0] & bit_en);
    end
endmodule

// File: rtl/phyctl_sync.sv
// Two-flop synchronizer for a vector of slow, level-type status inputs.
// Assumes bits are independent; no multi-bit coherence is provided.
module phyctl_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Shift the inputs through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/phyctl_rdmux.sv
// Registered read path: selects a control or status word by word index.
// Assumes unmapped indices read as zero and the upper half is always zero.
module phyctl_rdmux
    import phyctl_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rd,
    input  logic [WIDX_W-1:0]                  widx,
    input  logic [NUM_CTRL-1:0][HALF_W-1:0]    ctrl,
    input  logic [HALF_W-1:0]                  stat,
    output logic [DATA_W-1:0]                  rdata
);
    logic [HALF_W-1:0] pick;

    // Choose the addressed word, zero when nothing matches.
    always_comb begin
        pick = '0;
        if (widx == STAT_WIDX)
            pick = stat;
        for (int i = 0; i < NUM_CTRL; i++)
            if (widx == ctrl_widx(i))
                pick = ctrl[i];
    end

    // Capture the read result one edge after the request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd)
            rdata <= {{(DATA_W-HALF_W){1'b0}}, pick};
    end
endmodule

// File: rtl/phyctl_regbank.sv
// Top of the PHY control bank: six masked control words, one synchronized
// status word, registered readback. Assumes one bus access per cycle.
module phyctl_regbank
    import phyctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              st_cal_done,
    input  logic              st_dll_rdy,
    input  logic [3:0]        st_trim,
    input  logic              st_ext_res_absent,
    output logic [1:0]        freq_sel,
    output logic              otap_en,
    output logic [3:0]        otap_sel,
    output logic              itap_win,
    output logic [4:0]        itap_sel,
    output logic              itap_en,
    output logic [LANE_W-1:0] pad_rxen,
    output logic [LANE_W-1:0] pad_pullup,
    output logic [LANE_W-1:0] pad_odrel,
    output logic [LANE_W-1:0] pad_oden,
    output logic [3:0]        dll_trim,
    output logic              retrim_en,
    output logic              retrim_go,
    output logic [2:0]        drv_type,
    output logic [1:0]        retain_ctl,
    output logic              dll_en,
    output logic              pwr_up
);
    logic [WIDX_W-1:0]              widx;
    logic [NUM_CTRL-1:0][HALF_W-1:0] ctrl_q;
    logic [STAT_W-1:0]              stat_raw;
    logic [STAT_W-1:0]              stat_s;
    logic [HALF_W-1:0]              stat_word;

    // Word index from the byte address.
    always_comb widx = bus_addr[ADDR_W-1:2];

    // One masked register per control word.
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        logic hit;
        always_comb hit = bus_wr && (widx == ctrl_widx(g));
        phyctl_masked_reg #(
            .W    (HALF_W),
            .IMPL (ctrl_impl(g))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (hit),
            .wdata (bus_wdata),
            .q     (ctrl_q[g])
        );
    end

    // Gather the status inputs into their read positions.
    always_comb stat_raw = {st_cal_done, st_dll_rdy, st_trim, st_ext_res_absent};

    phyctl_sync #(.W(STAT_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_raw),
        .q     (stat_s)
    );

    // Place the synchronized status in the low bits of the status word.
    always_comb stat_word = {{(HALF_W-STAT_W){1'b0}}, stat_s};

    phyctl_rdmux u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .widx  (widx),
        .ctrl  (ctrl_q),
        .stat  (stat_word),
        .rdata (bus_rdata)
    );

    // Split the stored words onto the PHY control pins.
    always_comb begin
        freq_sel   = ctrl_q[0][13:12];
        otap_en    = ctrl_q[0][11];
        otap_sel   = ctrl_q[0][10:7];
        itap_win   = ctrl_q[0][6];
        itap_sel   = ctrl_q[0][5:1];
        itap_en    = ctrl_q[0][0];
        pad_rxen   = ctrl_q[1][LANE_W-1:0];
        pad_pullup = ctrl_q[2][LANE_W-1:0];
        pad_odrel  = ctrl_q[3][LANE_W-1:0];
        pad_oden   = ctrl_q[4][LANE_W-1:0];
        dll_trim   = ctrl_q[5][12:9];
        retrim_en  = ctrl_q[5][8];
        retrim_go  = ctrl_q[5][7];
        drv_type   = ctrl_q[5][6:4];
        retain_ctl = ctrl_q[5][3:2];
        dll_en     = ctrl_q[5][1];
        pwr_up     = ctrl_q[5][0];
    end
endmodule

// File: rtl/phyctl_regbank_chk.sv
// Checker for phyctl_regbank: port-level temporal properties, bound below.
module phyctl_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [1:0]  freq_sel,
    input logic [9:0]  pad_rxen,
    input logic [2:0]  drv_type,
    input logic        dll_en,
    input logic        pwr_up
);
    logic [3:0] widx;
    logic       mapped;

    // Word index and whether it names a control word.
    always_comb begin
        widx   = bus_addr[5:2];
        mapped = (widx == 4'd0) || ((widx >= 4'd2) && (widx <= 4'd6));
    end

    a_r1_empty_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_wdata[31:16] == 16'h0) |=>
        ($stable(freq_sel) && $stable(pad_rxen) && $stable(drv_type) &&
         $stable(dll_en) && $stable(pwr_up)));

    a_r2_freq_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == 4'd0 && bus_wdata[29:28] == 2'b11) |=>
        (freq_sel == $past(bus_wdata[13:12])));

    a_r3_pwrup_written: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == 4'd6 && bus_wdata[16]) |=>
        (pwr_up == $past(bus_wdata[0])));

    a_r3_pwrup_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == 4'd6 && !bus_wdata[16]) |=> $stable(pwr_up));

    a_r6_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=>
        ($stable(freq_sel) && $stable(pad_rxen) && $stable(drv_type) &&
         $stable(dll_en) && $stable(pwr_up)));

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rdata[31:16] == 16'h0));

    a_r7_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped && widx != 4'd8) |=> (bus_rdata == 32'h0));

    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!pwr_up && !dll_en && freq_sel == 2'b00 && bus_rdata == 32'h0));
endmodule

bind phyctl_regbank phyctl_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .freq_sel  (freq_sel),
    .pad_rxen  (pad_rxen),
    .drv_type  (drv_type),
    .dll_en    (dll_en),
    .pwr_up    (pwr_up)
);

// File: tb/phyctl_regbank_test.sv
`timescale 1ns/1ps
// Bench: walks a write/readback vector table, then directed checks.
module phyctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        st_cal_done = 1'b0;
    logic        st_dll_rdy = 1'b0;
    logic [3:0]  st_trim = '0;
    logic        st_ext_res_absent = 1'b0;
    logic [1:0]  freq_sel;
    logic        otap_en;
    logic [3:0]  otap_sel;
    logic        itap_win;
    logic [4:0]  itap_sel;
    logic        itap_en;
    logic [9:0]  pad_rxen, pad_pullup, pad_odrel, pad_oden;
    logic [3:0]  dll_trim;
    logic        retrim_en, retrim_go;
    logic [2:0]  drv_type;
    logic [1:0]  retain_ctl;
    logic        dll_en, pwr_up;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phyctl_regbank uut (.*);

    // {byte address, write data, expected low-half readback}
    localparam int NV = 12;
    localparam logic [53:0] VEC [NV] = '{
        {6'h00, 32'hFFFF_2A55, 16'h2A55},
        {6'h00, 32'h0001_0000, 16'h2A54},
        {6'h00, 32'h3000_FFFF, 16'h3A54},
        {6'h08, 32'hFFFF_01A5, 16'h01A5},
        {6'h0C, 32'h0300_0300, 16'h0300},
        {6'h10, 32'h03FF_FFFF, 16'h03FF},
        {6'h10, 32'h0100_0000, 16'h02FF},
        {6'h14, 32'h0000_FFFF, 16'h0000},
        {6'h18, 32'hFFFF_FFFF, 16'h1FFF},
        {6'h18, 32'h0003_0000, 16'h1FFC},
        {6'h04, 32'hFFFF_FFFF, 16'h0000},
        {6'h20, 32'hFFFF_FFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 pwr_up/dll_en after reset", {30'h0, pwr_up, dll_en}, 32'h0);
        chk("R8 rdata after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][53:48], VEC[i][47:16]);
            rd(VEC[i][53:48], r);
            chk($sformatf("R1/R6/R7/R9 vector %0d", i), r, {16'h0, VEC[i][15:0]});
        end

        // R2: timing word fields on ports (stored 0x3A54)
        chk("R2 fields", {18'h0, freq_sel, otap_en, otap_sel, itap_win, itap_sel, itap_en},
            {18'h0, 14'h3A54});
        // R4: lane words on ports
        chk("R4 rxen", {22'h0, pad_rxen}, 32'h1A5);
        chk("R4 pullup", {22'h0, pad_pullup}, 32'h300);
        chk("R4 odrel", {22'h0, pad_odrel}, 32'h2FF);
        chk("R4 oden", {22'h0, pad_oden}, 32'h000);
        // R3: power/DLL word on ports (stored 0x1FFC)
        chk("R3 fields", {19'h0, dll_trim, retrim_en, retrim_go, drv_type, retain_ctl, dll_en, pwr_up},
            {19'h0, 13'h1FFC});
        // R3: power up alone under a single-bit mask
        wr(6'h18, 32'h0001_0001);
        chk("R3 pwr_up set by single mask", {31'h0, pwr_up}, 32'h1);
        chk("R3 dll_en untouched", {31'h0, dll_en}, 32'h0);

        // R6: every-bit write to unmapped high address, then read it
        wr(6'h3C, 32'hFFFF_FFFF);
        chk("R6 power word kept", {19'h0, dll_trim, retrim_en, retrim_go, drv_type, retain_ctl, dll_en, pwr_up},
            32'h1FFD);
        rd(6'h1C, r);
        chk("R7 unmapped read zero", r, 32'h0);

        // R5: status layout after synchronizer settles
        st_cal_done = 1'b1; st_dll_rdy = 1'b0; st_trim = 4'b1011; st_ext_res_absent = 1'b0;
        repeat (3) @(negedge clk);
        rd(6'h20, r);
        chk("R5 status word", r, 32'h0000_0056);
        // R5: first-edge read after a change still shows old value
        st_dll_rdy = 1'b1; st_ext_res_absent = 1'b1;
        rd(6'h20, r);
        chk("R5 two-flop latency", r, 32'h0000_0056);
        rd(6'h20, r);
        chk("R5 status after settle", r, 32'h0000_0077);

        // R8: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R8 pwr_up cleared", {31'h0, pwr_up}, 32'h0);
        chk("R8 timing word cleared", {18'h0, freq_sel, otap_en, otap_sel, itap_win, itap_sel, itap_en}, 32'h0);
        rd(6'h18, r);
        chk("R8 power word reads zero", r, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule